// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load-Use Stall Control

This block resolves read-after-write dependences for a five-stage in-order integer pipeline. It resolves them while the consumer instruction is still in decode. Two source register numbers come from the decode stage. The block compares each of them with the destination numbers of the two older instructions. The first of these sits in the execute-stage pipeline register and the second in the memory-stage pipeline register. For each operand the block returns a 2-bit select that tells the operand multiplexer where to take the value from.

When the instruction in execute is a load and the decode instruction needs its result, the value cannot arrive in time. The block then freezes the program counter and the decode register for one cycle and zeroes the control fields entering execute. The load keeps moving. On the following cycle the dependent instruction picks the loaded value up through the memory-stage bypass path.

The block is purely combinational. It sits between the decode register, the execute register and the fetch logic. The register file, the ALU, data memory and branch resolution lie outside it.

Top module: `operand_bypass_ctl`

## Requirements
- R1: `sel_a` is 2'b01 (take the ALU result of the instruction in execute) when `dec_src_a` equals `ex_dst`, `ex_dst` is non-zero and `ex_wr` is 1.
- R2: `sel_a` is 2'b10 (take the ALU result or load data held in the memory stage) when `dec_src_a` equals `mem_dst`, `mem_dst` is non-zero, `mem_wr` is 1, and the R1 condition does not hold.
- R3: When both older instructions write the register named by a source, the select points at the execute-stage instruction (2'b01), because it is the more recent one.
- R4: A select is 2'b00 (register file value) when no qualifying match exists. A match does not qualify if the destination is register 0 or if that stage's write flag is 0. The value 2'b11 never appears.
- R5: `sel_b` follows the rules of R1 to R4 using `dec_src_b`, independently of `sel_a`.
- R6: A load-use stall is raised exactly when `ex_ld` is 1, `ex_dst` is non-zero, and `ex_dst` equals `dec_src_a` or `dec_src_b`.
- R7: During a stall `pc_we` and `dec_we` are 0 and `ex_bubble` is 1. Otherwise `pc_we` and `dec_we` are 1 and `ex_bubble` is 0.
- R8: In a pipeline built around the block, a load followed directly by an instruction that reads its destination holds that instruction in decode for exactly one stalled cycle. On the next cycle its operand select is 2'b10.
- R9: For the sequence load r4, then add r7 = r5 + r6, then sub r8 = r4 - r7, with no stall, the sub sees `sel_a` = 2'b10 and `sel_b` = 2'b01 while it is in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | REG_W | First source register number of the decode instruction |
| dec_src_b | input | REG_W | Second source register number of the decode instruction |
| ex_dst | input | REG_W | Destination register number held in the execute-stage register |
| ex_wr | input | 1 | Register-write flag of the execute-stage instruction |
| ex_ld | input | 1 | Memory-read (load) flag of the execute-stage instruction |
| mem_dst | input | REG_W | Destination register number held in the memory-stage register |
| mem_wr | input | 1 | Register-write flag of the memory-stage instruction |
| sel_a | output | 2 | Bypass select for operand A (00 file, 01 execute, 10 memory) |
| sel_b | output | 2 | Bypass select for operand B (same encoding) |
| pc_we | output | 1 | Program counter write enable, low during a stall |
| dec_we | output | 1 | Decode-register write enable, low during a stall |
| ex_bubble | output | 1 | Clears the control fields loaded into the execute register |

## Verification
The bench sweeps every combination of four register numbers, including register 0, together with the three stage flags. This covers the corner cases that break hazard units:
- A design that reversed the priority would feed a stale value from the older instruction whenever both stages write the same register.
- A design that forgot the register-0 guard would bypass a discarded result in place of the hard zero.
- A design that ignored the write flag would forward from stores and bubbles.

A small pipeline in the bench then runs real sequences. A stall that lasted zero or two cycles would show up as a wrong stall count, and so would a load-use check keyed to the wrong operand. A missing 10 path after the stall would show up as a wrong select on the following cycle.

// File: rtl/operand_bypass_ctl.sv
module operand_bypass_ctl #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             ex_ld,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             pc_we,
  output logic             dec_we,
  output logic             ex_bubble
);

  localparam logic [1:0] SEL_FILE = 2'b00;
  localparam logic [1:0] SEL_EX   = 2'b01;
  localparam logic [1:0] SEL_MEM  = 2'b10;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic ex_live, mem_live;
  logic a_ex, a_mem, b_ex, b_mem;
  logic load_use;

  assign ex_live  = ex_wr  && (ex_dst  != ZERO_REG);
  assign mem_live = mem_wr && (mem_dst != ZERO_REG);

  assign a_ex  = ex_live  && (dec_src_a == ex_dst);
  assign a_mem = mem_live && (dec_src_a == mem_dst);
  assign b_ex  = ex_live  && (dec_src_b == ex_dst);
  assign b_mem = mem_live && (dec_src_b == mem_dst);

  assign sel_a = a_ex ? SEL_EX : (a_mem ? SEL_MEM : SEL_FILE);
  assign sel_b = b_ex ? SEL_EX : (b_mem ? SEL_MEM : SEL_FILE);

  assign load_use = ex_ld && (ex_dst != ZERO_REG) &&
                    ((ex_dst == dec_src_a) || (ex_dst == dec_src_b));

  assign pc_we     = !load_use;
  assign dec_we    = !load_use;
  assign ex_bubble = load_use;

  always_comb begin
    if (!$isunknown({dec_src_a, dec_src_b, ex_dst, ex_wr, ex_ld, mem_dst, mem_wr})) begin
      AST_SEL_A_NEAR: assert (sel_a != SEL_EX || (ex_wr && ex_dst != ZERO_REG && dec_src_a == ex_dst)) else $error("sel_a ex path without qualifying match"); // R1
      AST_SEL_A_FAR: assert (sel_a != SEL_MEM || (mem_wr && mem_dst != ZERO_REG && dec_src_a == mem_dst)) else $error("sel_a mem path without qualifying match"); // R2
      AST_PRIO_A: assert (!(ex_wr && ex_dst != ZERO_REG && dec_src_a == ex_dst) || sel_a == SEL_EX) else $error("sel_a ignored nearer producer"); // R3
      AST_ZERO_A: assert (dec_src_a != ZERO_REG || sel_a == SEL_FILE) else $error("register 0 bypassed on A"); // R4
      AST_SEL_LEGAL: assert (sel_a != 2'b11 && sel_b != 2'b11) else $error("illegal select code"); // R4
      AST_ZERO_B: assert (dec_src_b != ZERO_REG || sel_b == SEL_FILE) else $error("register 0 bypassed on B"); // R5
      AST_PRIO_B: assert (!(ex_wr && ex_dst != ZERO_REG && dec_src_b == ex_dst) || sel_b == SEL_EX) else $error("sel_b ignored nearer producer"); // R5
      AST_NO_LD_NO_STALL: assert (ex_ld || pc_we) else $error("stall without load in execute"); // R6
      AST_FREEZE_PAIR: assert (pc_we == dec_we && ex_bubble == !pc_we) else $error("stall controls disagree"); // R7
    end
  end

endmodule

// File: tb/test_operand_bypass_ctl.sv
module test_operand_bypass_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;

  typedef struct packed {
    logic [W-1:0] rs;
    logic [W-1:0] rt;
    logic [W-1:0] rd;
    logic         wr;
    logic         ld;
    logic [7:0]   tag;
  } instr_t;

  localparam instr_t NOP = '{rs: '0, rt: '0, rd: '0, wr: 1'b0, ld: 1'b0, tag: 8'hFF};

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic         pl_on = 1'b0;
  logic [W-1:0] s_a = '0, s_b = '0, s_ex = '0, s_mem = '0;
  logic         s_exwr = 1'b0, s_exld = 1'b0, s_memwr = 1'b0;

  instr_t prog [8];
  instr_t ifid, idex, exmem;
  int     pc;

  logic [W-1:0] dec_src_a, dec_src_b, ex_dst, mem_dst;
  logic ex_wr, ex_ld, mem_wr;
  logic [1:0] sel_a, sel_b;
  logic pc_we, dec_we, ex_bubble;

  assign dec_src_a = pl_on ? ifid.rs  : s_a;
  assign dec_src_b = pl_on ? ifid.rt  : s_b;
  assign ex_dst    = pl_on ? idex.rd  : s_ex;
  assign ex_wr     = pl_on ? idex.wr  : s_exwr;
  assign ex_ld     = pl_on ? idex.ld  : s_exld;
  assign mem_dst   = pl_on ? exmem.rd : s_mem;
  assign mem_wr    = pl_on ? exmem.wr : s_memwr;

  operand_bypass_ctl #(.REG_W(W)) i_operand_bypass_ctl (
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_ld(ex_ld),
    .mem_dst(mem_dst), .mem_wr(mem_wr),
    .sel_a(sel_a), .sel_b(sel_b),
    .pc_we(pc_we), .dec_we(dec_we), .ex_bubble(ex_bubble)
  );

  always @(posedge clk) begin
    if (!pl_on) begin
      ifid <= NOP; idex <= NOP; exmem <= NOP; pc <= 0;
    end else begin
      exmem <= idex;
      idex  <= ex_bubble ? NOP : ifid;
      if (dec_we) ifid <= (pc < 8) ? prog[pc] : NOP;
      if (pc_we) pc <= pc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input int src, input int e, input bit ew,
                                          input int m, input bit mw);
    if (ew && e != 0 && src == e) return 2'b01;
    if (mw && m != 0 && src == m) return 2'b10;
    return 2'b00;
  endfunction

  function automatic instr_t mk(input int rs, input int rt, input int rd,
                                input bit wr, input bit ld, input int tag);
    instr_t t;
    t.rs = W'(rs); t.rt = W'(rt); t.rd = W'(rd); t.wr = wr; t.ld = ld; t.tag = 8'(tag);
    return t;
  endfunction

  task automatic start_prog();
    pl_on = 1'b0;
    repeat (2) @(negedge clk);
    pl_on = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset-like idle state: everything zero, no bypass, no stall
    @(negedge clk);
    chk(sel_a == 2'b00, "R4 idle sel_a", sel_a, 0);
    chk(sel_b == 2'b00, "R5 idle sel_b", sel_b, 0);
    chk(pc_we && dec_we && !ex_bubble, "R7 idle controls", {pc_we, dec_we, ex_bubble}, 3'b110);

    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int e = 0; e < 4; e++)
          for (int m = 0; m < 4; m++)
            for (int f = 0; f < 8; f++) begin
              logic [1:0] ea, eb;
              bit ew, el, mw, st;
              string ta;
              ew = f[0]; el = f[1]; mw = f[2];
              s_a = W'(a); s_b = W'(b); s_ex = W'(e); s_mem = W'(m);
              s_exwr = ew; s_exld = el; s_memwr = mw;
              #1;
              ea = exp_sel(a, e, ew, m, mw);
              eb = exp_sel(b, e, ew, m, mw);
              st = el && e != 0 && (e == a || e == b);
              if (ea == 2'b01 && mw && m == a) ta = "R3";
              else if (ea == 2'b01) ta = "R1";
              else if (ea == 2'b10) ta = "R2";
              else ta = "R4";
              chk(sel_a == ea, ta, sel_a, ea);
              chk(sel_b == eb, "R5", sel_b, eb);
              chk(pc_we == !st, "R6 pc_we", pc_we, !st);
              chk(dec_we == !st && ex_bubble == st, "R7", {dec_we, ex_bubble}, {!st, st});
            end

    // load r4; add r7=r5+r6; sub r8=r4-r7
    prog[0] = mk(9, 0, 4, 1, 1, 0);
    prog[1] = mk(5, 6, 7, 1, 0, 1);
    prog[2] = mk(4, 7, 8, 1, 0, 2);
    for (int i = 3; i < 8; i++) prog[i] = NOP;
    start_prog();
    begin
      bit seen = 0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (ifid.tag == 8'd2 && !seen) begin
          seen = 1;
          chk(sel_a == 2'b10, "R9 sel_a", sel_a, 2);
          chk(sel_b == 2'b01, "R9 sel_b", sel_b, 1);
          chk(pc_we == 1'b1, "R9 no stall", pc_we, 1);
        end
      end
      chk(seen, "R9 sub reached decode", seen, 1);
    end

    // load r2; and r4=r2&r5; or r6=r3|r2
    prog[0] = mk(1, 0, 2, 1, 1, 0);
    prog[1] = mk(2, 5, 4, 1, 0, 1);
    prog[2] = mk(3, 2, 6, 1, 0, 2);
    for (int i = 3; i < 8; i++) prog[i] = NOP;
    start_prog();
    begin
      int stalls = 0;
      bit got = 0;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (ifid.tag == 8'd1) begin
          if (!pc_we) stalls++;
          else if (!got) begin
            got = 1;
            chk(sel_a == 2'b10, "R8 bypass after stall", sel_a, 2);
          end
        end
      end
      chk(stalls == 1, "R8 stall length", stalls, 1);
      chk(got, "R8 dependent resumed", got, 1);
    end

    pl_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule